// File: doc/BRIEF.md
# Converter Ordering Self-Test Checker

This block sits behind a data converter during a built-in self-test in which a linearly rising stimulus sweeps the converter's input range. Each time the converter delivers a result, it strobes a valid line. The checker holds the result from the previous conversion and compares the new one against it. It counts every comparison in which the code did not go down.

A test begins with a one-cycle start pulse and runs for a programmed number of valid samples. After the last sample, the checker raises a done flag. It also raises a pass flag when the accumulated count equals a programmed expected total. The count stays readable at the port, so a failing part can be diagnosed. It shows how many steps kept their order.

Top module: `mono_bist_top`

## Requirements
- R1: After reset, done_o, pass_o and count_o are all zero, and no test is running.
- R2: The first valid sample after a start only loads the previous-code register. It is not compared and does not change count_o.
- R3: Each later valid sample whose code is greater than or equal to the previous code, compared as unsigned, increments count_o by exactly one. Equal codes count as passing.
- R4: A valid sample whose code is strictly lower than the previous code leaves count_o unchanged. That lower code becomes the previous code for the next comparison.
- R5: In a cycle where code_valid_i is low, code_i is ignored and neither the count nor the previous code changes.
- R6: The test ends on the valid sample whose ordinal reaches sample_num_i, where the first sample after start is ordinal 1. done_o goes high in the cycle after that sample is presented. A sample_num_i of 0 or 1 ends the test on the first sample.
- R7: When done_o rises, pass_o equals (final count_o == expect_i). pass_o is never high while done_o is low.
- R8: After done_o is high, further valid samples are ignored. count_o, done_o and pass_o hold until the next start.
- R9: start_i is synchronous. In the cycle after it is high, count_o, done_o and pass_o are zero, and the previous code is cleared. A sample strobed in the same cycle as start_i is ignored. A start during a running test restarts it.
- R10: count_o saturates at 2^CNT_W-1 and never wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a new test and clears all results |
| sample_num_i | input | SAMP_W | Number of valid samples in the test |
| expect_i | input | CNT_W | Expected number of passing comparisons |
| code_valid_i | input | 1 | Strobe marking a new converter result |
| code_i | input | CODE_W | Converter output code |
| done_o | output | 1 | Test finished |
| pass_o | output | 1 | Final count matched the expected total |
| count_o | output | CNT_W | Running and final count of passing comparisons |

## Verification
The bench drives several stimulus patterns:
- A clean unit-step ramp and a flat run of equal codes. These separate a greater-or-equal comparison from a strictly-greater one.
- A sequence with dips. This shows whether a lower code is counted, and whether it replaces the previous code or is skipped.
- Samples separated by idle cycles carrying junk codes. These tell whether the strobe, rather than the clock, drives the comparison.
- A single-sample test, a restart in mid-test with a sample in the start cycle, and a ramp longer than the counter range. These cover first-sample handling, clearing and saturation.

// File: rtl/mono_bist_pkg.sv
package mono_bist_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bist_st_t;
endpackage

// File: rtl/mono_seq.sv
module mono_seq
  import mono_bist_pkg::*;
#(
  parameter int SAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [SAMP_W-1:0] samp_num_i,
  input  logic              match_i,
  output logic              take_o,
  output logic              first_o,
  output logic              done_o,
  output logic              pass_o
);
  bist_st_t          st_q;
  logic [SAMP_W-1:0] seen_q;
  logic [SAMP_W:0]   seen_inc;
  logic              last;

  always_comb begin
    take_o   = (st_q == ST_RUN) && valid_i && !start_i;
    first_o  = take_o && (seen_q == '0);
    seen_inc = {1'b0, seen_q} + 1'b1;
    last     = take_o && (seen_inc >= {1'b0, samp_num_i});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      seen_q <= '0;
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else if (start_i) begin
      st_q   <= ST_RUN;
      seen_q <= '0;
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else if (take_o) begin
      seen_q <= seen_inc[SAMP_W-1:0];
      if (last) begin
        st_q   <= ST_IDLE;
        done_o <= 1'b1;
        pass_o <= match_i;
      end
    end
  end

  // R6: the final sample is followed by done
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    last |=> done_o);
  // R8: done persists until a new start
  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);
  // R8: no sample is accepted once the test has finished
  p_no_take_done_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !take_o);
endmodule

// File: rtl/mono_cmp.sv
module mono_cmp #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic              first_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              ok_o
);
  logic [CODE_W-1:0] prev_q;

  always_comb ok_o = take_i && !first_i && (code_i >= prev_q);

  always_ff @(posedge clk) begin
    if (rst || clr_i) prev_q <= '0;
    else if (take_i)  prev_q <= code_i;
  end

  // R5: the previous code only moves on an accepted sample
  p_prev_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!take_i && !clr_i) |=> $stable(prev_q));
  // R4: every accepted sample, passing or not, becomes the new reference
  p_prev_load_r4: assert property (@(posedge clk) disable iff (rst)
    (take_i && !clr_i) |=> prev_q == $past(code_i));
endmodule

// File: rtl/mono_cnt.sv
module mono_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_comb begin
    if (clr_i)                          cnt_nxt_o = '0;
    else if (inc_i && cnt_o != CNT_MAX) cnt_nxt_o = cnt_o + CNT_ONE;
    else                                cnt_nxt_o = cnt_o;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_nxt_o;
  end

  // R10: a full counter stays full
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);
  // R3: without a clear the count moves by zero or one
  p_unit_step_r3: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + CNT_ONE));
endmodule

// File: rtl/mono_bist_top.sv
module mono_bist_top #(
  parameter int CODE_W = 12,
  parameter int CNT_W  = 16,
  parameter int SAMP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SAMP_W-1:0] sample_num_i,
  input  logic [CNT_W-1:0]  expect_i,
  input  logic              code_valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [CNT_W-1:0]  count_o
);
  logic             take;
  logic             first;
  logic             step_ok;
  logic             match;
  logic [CNT_W-1:0] cnt_nxt;

  mono_seq #(.SAMP_W(SAMP_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .valid_i(code_valid_i),
    .samp_num_i(sample_num_i), .match_i(match),
    .take_o(take), .first_o(first), .done_o(done_o), .pass_o(pass_o)
  );

  mono_cmp #(.CODE_W(CODE_W)) u_cmp (
    .clk(clk), .rst(rst), .clr_i(start_i), .take_i(take),
    .first_i(first), .code_i(code_i), .ok_o(step_ok)
  );

  mono_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(start_i), .inc_i(step_ok),
    .cnt_o(count_o), .cnt_nxt_o(cnt_nxt)
  );

  always_comb match = (cnt_nxt == expect_i);

  // R9: start clears every result in the next cycle
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (count_o == '0) && !done_o && !pass_o);
  // R7: pass only accompanies done
  p_pass_gate_r7: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> done_o);
  // R7: verdict matches the final count
  p_verdict_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (pass_o == (count_o == expect_i)));
  // R8: results frozen after the test ends
  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> $stable(count_o) && $stable(pass_o));
endmodule

// File: tb/mono_bist_top_test.sv
module mono_bist_top_test;
  localparam int CODE_W = 10;
  localparam int CNT_W  = 4;
  localparam int SAMP_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [SAMP_W-1:0] sample_num_i = '0;
  logic [CNT_W-1:0]  expect_i = '0;
  logic              code_valid_i = 1'b0;
  logic [CODE_W-1:0] code_i = '0;
  logic              done_o;
  logic              pass_o;
  logic [CNT_W-1:0]  count_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mono_bist_top #(.CODE_W(CODE_W), .CNT_W(CNT_W), .SAMP_W(SAMP_W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .sample_num_i(sample_num_i),
    .expect_i(expect_i), .code_valid_i(code_valid_i), .code_i(code_i),
    .done_o(done_o), .pass_o(pass_o), .count_o(count_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic begin_test(input int num, input int exp);
    @(negedge clk);
    start_i = 1'b1;
    sample_num_i = SAMP_W'(num);
    expect_i = CNT_W'(exp);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input int code);
    @(negedge clk);
    code_valid_i = 1'b1;
    code_i = CODE_W'(code);
    @(negedge clk);
    code_valid_i = 1'b0;
    code_i = CODE_W'(1023);
  endtask

  task automatic t_reset;
    chk("R1 done", done_o, 0);
    chk("R1 pass", pass_o, 0);
    chk("R1 count", count_o, 0);
    send(5);
    chk("R1 idle ignores samples", count_o, 0);
  endtask

  task automatic t_ramp;
    begin_test(8, 7);
    for (int i = 0; i < 7; i++) send(i * 3);
    chk("R6 done low before last", done_o, 0);
    chk("R3 ramp partial", count_o, 6);
    send(40);
    chk("R3 ramp count", count_o, 7);
    chk("R6 done", done_o, 1);
    chk("R7 pass on match", pass_o, 1);
  endtask

  task automatic t_flat;
    begin_test(5, 4);
    for (int i = 0; i < 5; i++) send(100);
    chk("R3 equal codes pass", count_o, 4);
    chk("R7 flat pass", pass_o, 1);
  endtask

  task automatic t_dip;
    begin_test(6, 5);
    send(10);
    send(20);
    send(15);
    chk("R4 dip not counted", count_o, 1);
    send(16);
    chk("R4 lower code becomes previous", count_o, 2);
    send(30);
    send(5);
    chk("R4 dip count", count_o, 3);
    chk("R6 dip done", done_o, 1);
    chk("R7 mismatch fails", pass_o, 0);
  endtask

  task automatic t_gaps;
    begin_test(4, 3);
    send(1);
    chk("R2 first sample not counted", count_o, 0);
    send(2);
    chk("R3 second counted", count_o, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      code_i = CODE_W'(i);
    end
    chk("R5 invalid cycles ignored", count_o, 1);
    send(3);
    chk("R5 previous kept across gap", count_o, 2);
    send(4);
    chk("R5 gap test count", count_o, 3);
    chk("R7 gap test pass", pass_o, 1);
  endtask

  task automatic t_after_done;
    send(0);
    send(0);
    chk("R8 count held", count_o, 3);
    chk("R8 done held", done_o, 1);
    chk("R8 pass held", pass_o, 1);
  endtask

  task automatic t_restart;
    begin_test(10, 0);
    send(50);
    send(60);
    @(negedge clk);
    start_i = 1'b1;
    sample_num_i = SAMP_W'(2);
    expect_i = CNT_W'(1);
    code_valid_i = 1'b1;
    code_i = CODE_W'(1000);
    @(negedge clk);
    start_i = 1'b0;
    code_valid_i = 1'b0;
    chk("R9 count cleared", count_o, 0);
    chk("R9 done cleared", done_o, 0);
    chk("R9 pass cleared", pass_o, 0);
    send(5);
    chk("R9 start-cycle sample ignored", done_o, 0);
    send(6);
    chk("R9 restart count", count_o, 1);
    chk("R9 restart done", done_o, 1);
    chk("R9 restart pass", pass_o, 1);
  endtask

  task automatic t_one;
    begin_test(1, 0);
    send(7);
    chk("R6 single sample done", done_o, 1);
    chk("R2 single sample count", count_o, 0);
    chk("R7 single sample pass", pass_o, 1);
    begin_test(0, 0);
    send(9);
    chk("R6 zero length ends on first", done_o, 1);
  endtask

  task automatic t_sat;
    begin_test(20, 15);
    for (int i = 0; i < 20; i++) send(i);
    chk("R10 saturated count", count_o, 15);
    chk("R10 saturated pass", pass_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ramp();
    t_flat();
    t_dip();
    t_gaps();
    t_after_done();
    t_restart();
    t_one();
    t_sat();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule